// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction of conditional branches whose outcome is not yet known at fetch time. It holds a table of two-bit saturating counters. Selected bits of the branch address index the table. A front end presents a branch address together with the static direction hint carried in the instruction. In the same cycle the block returns a predicted direction and a flag that says whether the table or the hint supplied it.

When a predicted branch resolves, the outcome is sent back on the update port. The addressed counter then moves one step toward taken or toward not taken. Branches that were resolved at fetch, and so never needed a prediction, are marked on the update port and leave the table untouched, which keeps aliasing low. A global enable switches between dynamic prediction and the static hint. While it is low the table is frozen.

Top module: `bht_predictor`

## Requirements
- R1: After an active-low asynchronous reset, every counter holds 01 (weakly not taken), so with the enable high every address predicts not taken.
- R2: The table index is address bits [10:2]; addresses that differ only outside those bits share a counter, and addresses that differ in any bit inside them use separate counters.
- R3: An accepted taken update adds one to the counter and holds it at 11 (strongly taken) when it is already there.
- R4: An accepted not-taken update subtracts one from the counter and holds it at 00 (strongly not taken) when it is already there.
- R5: With the enable high, the predicted direction is the counter's MSB (00 and 01 predict not taken, 10 and 11 predict taken), and the dynamic flag output is 1.
- R6: An update changes the table only when both the update-valid and was-predicted inputs are 1; otherwise it has no effect on any later prediction.
- R7: With the enable low, the predicted direction equals the static hint input and the dynamic flag output is 0.
- R8: With the enable low, updates are ignored and leave every counter unchanged.
- R9: When a prediction and an accepted update address the same counter in one cycle, the prediction in that cycle reflects the old counter value, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Dynamic prediction enable |
| pred_addr_i | input | ADDR_W | Address of the branch to predict |
| static_hint_i | input | 1 | Static direction hint from the instruction (1 = taken) |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| pred_dyn_o | output | 1 | 1 when the prediction came from the table |
| upd_valid_i | input | 1 | A resolved branch outcome is present |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome (1 = taken) |
| upd_was_pred_i | input | 1 | 1 when that branch's direction had to be predicted |

## Verification
A corrupted counter shows on pred_taken_o only when its MSB is wrong. A counter that wraps instead of saturating therefore stays hidden until the third or fourth same-direction update at one index. For that reason the bench drives long runs of one outcome and reads the address after every update. A write to the wrong index, or a write that should have been blocked, is visible in the cycle after the update edge. The bench catches it by reading neighbouring and aliased addresses and by reading counters it has never trained.

// File: rtl/bht_pkg.sv
package bht_pkg;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned IDX_LSB_DEF = 2;
  localparam int unsigned IDX_W_DEF   = 9;
  localparam int unsigned CNT_W_DEF   = 2;

  // weakly not taken: MSB clear, all lower bits set
  function automatic logic [CNT_W_DEF-1:0] ctr_init();
    logic [CNT_W_DEF-1:0] v;
    v = '1;
    v[CNT_W_DEF-1] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/bht_index_sel.sv
module bht_index_sel #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned IDX_W   = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  assign idx_o = addr_i[IDX_LSB +: IDX_W];
endmodule

// File: rtl/bht_sat_ctr.sv
module bht_sat_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] cur_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] CMax = '1;
  localparam logic [CNT_W-1:0] CMin = '0;
  localparam logic [CNT_W-1:0] COne = CNT_W'(1);

  always_comb begin
    nxt_o = cur_i;
    if (up_i) begin
      if (cur_i != CMax) nxt_o = cur_i + COne;
    end else begin
      if (cur_i != CMin) nxt_o = cur_i - COne;
    end
  end
endmodule

// File: rtl/bht_ctr_array.sv
module bht_ctr_array #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned CNT_W = 2,
  parameter logic [CNT_W-1:0] INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic [IDX_W-1:0] mod_idx_i,
  output logic [CNT_W-1:0] mod_cnt_o,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_cnt_i
);
  localparam int unsigned Depth = 1 << IDX_W;

  logic [CNT_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= INIT;
    end else if (wr_en_i) begin
      mem_q[mod_idx_i] <= wr_cnt_i;
    end
  end

  // asynchronous reads: same-cycle write is not forwarded
  assign rd_cnt_o  = mem_q[rd_idx_i];
  assign mod_cnt_o = mem_q[mod_idx_i];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int unsigned ADDR_W  = bht_pkg::ADDR_W_DEF,
  parameter int unsigned IDX_LSB = bht_pkg::IDX_LSB_DEF,
  parameter int unsigned IDX_W   = bht_pkg::IDX_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] pred_addr_i,
  input  logic              static_hint_i,
  output logic              pred_taken_o,
  output logic              pred_dyn_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_taken_i,
  input  logic              upd_was_pred_i
);
  localparam int unsigned CntW = bht_pkg::CNT_W_DEF;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [CntW-1:0]  rd_cnt, cur_cnt, nxt_cnt;
  logic             upd_acc;

  bht_index_sel #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_rd_idx (
    .addr_i(pred_addr_i), .idx_o(rd_idx)
  );
  bht_index_sel #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_wr_idx (
    .addr_i(upd_addr_i), .idx_o(wr_idx)
  );

  // only predicted branches train, and only while enabled
  assign upd_acc = upd_valid_i & upd_was_pred_i & en_i;

  bht_sat_ctr #(.CNT_W(CntW)) u_ctr (
    .cur_i(cur_cnt), .up_i(upd_taken_i), .nxt_o(nxt_cnt)
  );

  bht_ctr_array #(.IDX_W(IDX_W), .CNT_W(CntW), .INIT(bht_pkg::ctr_init())) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_cnt_o (rd_cnt),
    .mod_idx_i(wr_idx),
    .mod_cnt_o(cur_cnt),
    .wr_en_i  (upd_acc),
    .wr_cnt_i (nxt_cnt)
  );

  assign pred_dyn_o   = en_i;
  assign pred_taken_o = en_i ? rd_cnt[CntW-1] : static_hint_i;
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned IDX_W   = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [ADDR_W-1:0] pred_addr_i,
  input logic              static_hint_i,
  input logic              pred_taken_o,
  input logic              pred_dyn_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_taken_i,
  input logic              upd_was_pred_i
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  logic acc, same_idx;
  assign acc      = upd_valid_i & upd_was_pred_i & en_i;
  assign same_idx = upd_addr_i[IDX_LSB +: IDX_W] == pred_addr_i[IDX_LSB +: IDX_W];

  // R7
  static_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pred_taken_o == static_hint_i) && !pred_dyn_o);

  // R6
  no_stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && $past(en_i) && $stable(pred_addr_i) && !$past(acc)
    |-> $stable(pred_taken_o));

  // R3
  taken_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && $stable(pred_addr_i)
    && $past(acc && same_idx && upd_taken_i && pred_taken_o)
    |-> pred_taken_o);

  // R4
  not_taken_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && $stable(pred_addr_i)
    && $past(acc && same_idx && !upd_taken_i && !pred_taken_o)
    |-> !pred_taken_o);

  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && $past(!en_i) && $past(en_i, 2) && $stable(pred_addr_i)
    && $past(pred_addr_i, 2) == pred_addr_i && !$past(acc, 2)
    |-> pred_taken_o == $past(pred_taken_o, 2));
endmodule

bind bht_predictor bht_predictor_chk #(
  .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b1;
  logic [AW-1:0] pred_addr_i = '0;
  logic          static_hint_i = 1'b0;
  logic          pred_taken_o, pred_dyn_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_addr_i = '0;
  logic          upd_taken_i = 1'b0;
  logic          upd_was_pred_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  bht_predictor dut_i (.*);

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic upd(input logic [AW-1:0] a, input logic t, input logic wp, input logic v);
    @(negedge clk_i);
    upd_addr_i = a; upd_taken_i = t; upd_was_pred_i = wp; upd_valid_i = v;
    @(posedge clk_i);
    #1 upd_valid_i = 1'b0; upd_was_pred_i = 1'b0;
  endtask

  task automatic pred(input logic [AW-1:0] a, input logic hint, input logic exp, input string req);
    @(negedge clk_i);
    pred_addr_i = a; static_hint_i = hint;
    #1 check(pred_taken_o, exp, req);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) pred(AW'(i * 132), 1'b1, 1'b0, "R1");
    check(pred_dyn_o, 1'b1, "R5 dyn flag");
  endtask

  task automatic t_up();
    upd(32'h0, 1, 1, 1); pred(32'h0, 0, 1'b1, "R5 10 predicts taken");
    upd(32'h0, 1, 1, 1); pred(32'h0, 0, 1'b1, "R3 11");
    upd(32'h0, 1, 1, 1); pred(32'h0, 0, 1'b1, "R3 saturate at 11");
    upd(32'h0, 0, 1, 1); pred(32'h0, 0, 1'b1, "R3 held 11 then 10");
    upd(32'h0, 0, 1, 1); pred(32'h0, 0, 1'b0, "R5 01 predicts not taken");
  endtask

  task automatic t_down();
    upd(32'h10, 0, 1, 1); pred(32'h10, 1, 1'b0, "R4 00");
    upd(32'h10, 0, 1, 1); pred(32'h10, 1, 1'b0, "R4 saturate at 00");
    upd(32'h10, 0, 1, 1); pred(32'h10, 1, 1'b0, "R4 saturate at 00");
    upd(32'h10, 1, 1, 1); pred(32'h10, 1, 1'b0, "R4 held 00 then 01");
    upd(32'h10, 1, 1, 1); pred(32'h10, 1, 1'b1, "R4 01 then 10");
  endtask

  task automatic t_index();
    upd(32'h100, 1, 1, 1); upd(32'h100, 1, 1, 1);
    pred(32'h100, 0, 1'b1, "R2 trained");
    pred(32'h100 ^ 32'h800, 0, 1'b1, "R2 alias bit 11");
    pred(32'h100 ^ 32'h8000_0000, 0, 1'b1, "R2 alias bit 31");
    pred(32'h101, 0, 1'b1, "R2 alias bit 0");
    pred(32'h104, 0, 1'b0, "R2 distinct bit 2");
    pred(32'h500, 0, 1'b0, "R2 distinct bit 10");
  endtask

  task automatic t_unpred();
    upd(32'h200, 1, 0, 1); upd(32'h200, 1, 0, 1);
    pred(32'h200, 0, 1'b0, "R6 was_pred low");
    upd(32'h200, 1, 1, 0); upd(32'h200, 1, 1, 0);
    pred(32'h200, 0, 1'b0, "R6 valid low");
    upd(32'h200, 1, 1, 1);
    pred(32'h200, 0, 1'b1, "R6 accepted");
  endtask

  task automatic t_disable();
    @(negedge clk_i); en_i = 1'b0;
    pred(32'h100, 1'b0, 1'b0, "R7 hint 0 over taken entry");
    check(pred_dyn_o, 1'b0, "R7 dyn flag");
    pred(32'h300, 1'b1, 1'b1, "R7 hint 1");
    upd(32'h300, 1, 1, 1); upd(32'h300, 1, 1, 1); upd(32'h300, 1, 1, 1);
    @(negedge clk_i); en_i = 1'b1;
    pred(32'h300, 1'b1, 1'b0, "R8 frozen while disabled");
  endtask

  task automatic t_same();
    pred(32'h380, 0, 1'b0, "R9 fresh");
    @(negedge clk_i);
    upd_addr_i = 32'h380; upd_taken_i = 1; upd_was_pred_i = 1; upd_valid_i = 1;
    #1 check(pred_taken_o, 1'b0, "R9 old value same cycle");
    @(posedge clk_i);
    #1 upd_valid_i = 1'b0; upd_was_pred_i = 1'b0;
    check(pred_taken_o, 1'b1, "R9 new value next cycle");
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check(pred_taken_o, 1'b0, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_up();
    t_down();
    t_index();
    t_unpred();
    t_disable();
    t_same();
    repeat (2) @(posedge clk_i);
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end
endmodule